// File: doc/BRIEF.md
# Multicart PRG Bank Translator

This block sits between the CPU bus of a multicart cartridge and its program ROM. CPU writes into the $8000-$9FFF region load a small set of banking registers. CPU reads in the $6000-$FFFF range are turned into ROM byte addresses. That range is split into five 8 KiB windows. Four windows can be switched. The top window is fixed to the last 8 KiB bank of the active outer bank. The outer bank covers 128 KiB of ROM and is chosen at run time. A size code narrows the inner bank number with an AND mask, so one ROM image can host games of 128, 256 or 512 KiB.

The block also holds the two-bit nametable mirroring mode. From it, and from the PPU address lines A10 and A11, it drives the select line for the upper half of the console nametable RAM. The address path is purely combinational, so a read sees the translated address in the same cycle. Register writes take effect at the next clock edge.

Top module: `prg_xlat_top`

## Requirements
- R1: After reset all four bank registers, the outer bank and the size code are 0 and the mirroring mode is vertical. A read at $8000 then maps to ROM address 0, and the nametable select follows PPU A10.
- R2: A register is chosen by the write address ANDed with $F003. Address bits 11:2 therefore play no part, so a write to $8FF6 reaches $8002 and a write to $9FF5 reaches $9001.
- R3: Writes to $8000, $8001 and $8002 set the inner bank for the CPU windows at $8000, $A000 and $C000. A write to $8003 sets the inner bank for $6000. Each stored inner bank is data bits 5:0.
- R4: The $E000-$FFFF window uses an inner bank of all ones, taken through the current mask. Its final bank number is therefore (outer << 4) OR mask.
- R5: A write to $9000 loads data bits 5:3 as the outer bank number. The final 8 KiB bank number is (outer << 4) OR (inner AND mask).
- R6: A write to $9001 loads data bits 1:0 as the size code. The resulting inner mask is $3F for code 0, $1F for code 1, $2F for code 2 and $0F for code 3.
- R7: The ROM byte address is the 7-bit final bank number in bits 19:13, concatenated with CPU A12:A0.
- R8: The ROM enable output is high only when the read strobe is high and the CPU address is $6000 or above.
- R9: A write to $9002 loads data bits 1:0 as the mirroring mode. The nametable select then equals PPU A10 for code 0, PPU A11 for code 1, constant 0 for code 2 and constant 1 for code 3.
- R10: Writes that decode to any other register leave every bank, outer, size and mirroring setting unchanged. This includes $9003, $A000-$B003, $C000-$F003 and addresses below $8000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | CPU bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | CPU write strobe, one cycle per write |
| wr_addr_i | input | 16 | CPU write address |
| wr_data_i | input | 8 | CPU write data |
| cpu_addr_i | input | 16 | CPU read address |
| cpu_rd_i | input | 1 | CPU read strobe |
| ppu_a10_i | input | 1 | PPU address bit 10 |
| ppu_a11_i | input | 1 | PPU address bit 11 |
| rom_addr_o | output | 20 | PRG-ROM byte address |
| rom_ce_o | output | 1 | PRG-ROM enable |
| ciram_a10_o | output | 1 | Nametable RAM half select |

## Verification
Each switchable window is loaded with a different bank value. A swapped window decode therefore shows up as a wrong address, not a matching one. The same inner bank value, with bits 5 and 4 both set, is read under all four size codes. This separates the odd $2F mask from $1F and $3F. A non-zero outer bank that overlaps those bits shows that outer and inner are ORed, not added. Aliased write addresses and writes to neighbouring unrelated registers show that only bits 15:12 and 1:0 decode. Mirroring is driven with opposite values on A10 and A11, so each mode picks a distinct source.

// File: rtl/prg_xlat_pkg.sv
package prg_xlat_pkg;
  localparam int OUTER_W = 3;
  localparam int INNER_W = 6;
  localparam int PAGE_W  = 13;
  localparam int NUM_WIN = 4;
  localparam int BANK_W  = OUTER_W + 4;
  localparam int ROM_AW  = BANK_W + PAGE_W;

  typedef enum logic [1:0] {
    MIR_VERT = 2'd0,
    MIR_HORZ = 2'd1,
    MIR_ONE0 = 2'd2,
    MIR_ONE1 = 2'd3
  } mir_mode_e;

  function automatic logic [INNER_W-1:0] size_mask(input logic [1:0] code);
    case (code)
      2'd0:    size_mask = 6'h3f;
      2'd1:    size_mask = 6'h1f;
      2'd2:    size_mask = 6'h2f;
      default: size_mask = 6'h0f;
    endcase
  endfunction
endpackage

// File: rtl/prg_regs.sv
module prg_regs
  import prg_xlat_pkg::*;
(
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              wr_en_i,
  input  logic [15:0]                       wr_addr_i,
  input  logic [7:0]                        wr_data_i,
  output logic [NUM_WIN-1:0][INNER_W-1:0]   bank_o,
  output logic [OUTER_W-1:0]                outer_o,
  output logic [1:0]                        size_o,
  output mir_mode_e                         mir_o
);
  localparam logic [15:0] DEC_MASK = 16'hf003;
  localparam logic [13:0] BANK_GRP = 14'h2000;  // $8000 >> 2
  localparam logic [13:0] MISC_GRP = 14'h2400;  // $9000 >> 2

  logic [15:0] dec;
  logic        bank_we, misc_we;
  logic        unused_data;

  assign dec         = wr_addr_i & DEC_MASK;
  assign bank_we     = wr_en_i && (dec[15:2] == BANK_GRP);
  assign misc_we     = wr_en_i && (dec[15:2] == MISC_GRP);
  assign unused_data = ^wr_data_i[7:6];

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_bank
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          bank_o[g] <= '0;
      else if (bank_we && dec[1:0] == 2'(g)) bank_o[g] <= wr_data_i[INNER_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      outer_o <= '0;
      size_o  <= '0;
      mir_o   <= MIR_VERT;
    end else if (misc_we) begin
      case (dec[1:0])
        2'd0:    outer_o <= wr_data_i[5:3];
        2'd1:    size_o  <= wr_data_i[1:0];
        2'd2:    mir_o   <= mir_mode_e'(wr_data_i[1:0]);
        default: ;  // CHR base, not handled here
      endcase
    end
  end

  // R5
  outer_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (wr_addr_i & 16'hf003) == 16'h9000) |=> outer_o == $past(wr_data_i[5:3]));
  // R6
  size_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (wr_addr_i & 16'hf003) == 16'h9001) |=> size_o == $past(wr_data_i[1:0]));
  // R9
  mir_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (wr_addr_i & 16'hf003) == 16'h9002) |=> mir_o == $past(wr_data_i[1:0]));
  // R10
  bank_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && wr_addr_i[15:12] == 4'h8) |=> $stable(bank_o));
  // R10
  misc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && wr_addr_i[15:12] == 4'h9) |=> ($stable(outer_o) && $stable(size_o) && $stable(mir_o)));
endmodule

// File: rtl/prg_addr_map.sv
module prg_addr_map
  import prg_xlat_pkg::*;
(
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [NUM_WIN-1:0][INNER_W-1:0]   bank_i,
  input  logic [OUTER_W-1:0]                outer_i,
  input  logic [1:0]                        size_i,
  input  logic [15:0]                       cpu_addr_i,
  input  logic                              cpu_rd_i,
  output logic [ROM_AW-1:0]                 rom_addr_o,
  output logic                              rom_ce_o
);
  logic [INNER_W-1:0] inner, mask;
  logic [BANK_W-1:0]  bank_num;

  assign mask = size_mask(size_i);

  always_comb begin
    case (cpu_addr_i[15:13])
      3'd3:    inner = bank_i[3];
      3'd4:    inner = bank_i[0];
      3'd5:    inner = bank_i[1];
      3'd6:    inner = bank_i[2];
      default: inner = '1;  // fixed top window
    endcase
  end

  assign bank_num   = {outer_i, 4'b0000} | BANK_W'(inner & mask);
  assign rom_addr_o = {bank_num, cpu_addr_i[PAGE_W-1:0]};
  assign rom_ce_o   = cpu_rd_i && (cpu_addr_i[15:13] >= 3'd3);

  // R4
  fixed_bank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_addr_i[15:13] == 3'd7 |-> rom_addr_o[PAGE_W+3:PAGE_W] == 4'hf);
  // R7
  offset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rom_addr_o[PAGE_W-1:0] == cpu_addr_i[PAGE_W-1:0]);
  // R8
  ce_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rom_ce_o |-> (cpu_rd_i && cpu_addr_i >= 16'h6000));
endmodule

// File: rtl/prg_mirror.sv
module prg_mirror
  import prg_xlat_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  mir_mode_e mode_i,
  input  logic      ppu_a10_i,
  input  logic      ppu_a11_i,
  output logic      ciram_a10_o
);
  always_comb begin
    case (mode_i)
      MIR_VERT: ciram_a10_o = ppu_a10_i;
      MIR_HORZ: ciram_a10_o = ppu_a11_i;
      MIR_ONE0: ciram_a10_o = 1'b0;
      default:  ciram_a10_o = 1'b1;
    endcase
  end

  // R9
  one_screen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i[1] |-> ciram_a10_o == mode_i[0]);
endmodule

// File: rtl/prg_xlat_top.sv
module prg_xlat_top
  import prg_xlat_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [15:0]       wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic [15:0]       cpu_addr_i,
  input  logic              cpu_rd_i,
  input  logic              ppu_a10_i,
  input  logic              ppu_a11_i,
  output logic [ROM_AW-1:0] rom_addr_o,
  output logic              rom_ce_o,
  output logic              ciram_a10_o
);
  logic [NUM_WIN-1:0][INNER_W-1:0] bank;
  logic [OUTER_W-1:0]              outer;
  logic [1:0]                      size;
  mir_mode_e                       mir;

  prg_regs i_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .bank_o(bank), .outer_o(outer), .size_o(size), .mir_o(mir)
  );

  prg_addr_map i_map (
    .clk_i, .rst_ni, .bank_i(bank), .outer_i(outer), .size_i(size),
    .cpu_addr_i, .cpu_rd_i, .rom_addr_o, .rom_ce_o
  );

  prg_mirror i_mir (
    .clk_i, .rst_ni, .mode_i(mir), .ppu_a10_i, .ppu_a11_i, .ciram_a10_o
  );
endmodule

// File: tb/test_prg_xlat_top.sv
module test_prg_xlat_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [15:0] cpu_addr = '0;
  logic        cpu_rd = 1'b0;
  logic        a10 = 1'b0, a11 = 1'b0;
  logic [19:0] rom_addr;
  logic        rom_ce, ciram;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // bench model
  logic [5:0] mb [4];
  logic [2:0] mo;
  logic [1:0] ms;

  always #10 clk = ~clk;

  prg_xlat_top i_prg_xlat_top (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .cpu_addr_i(cpu_addr), .cpu_rd_i(cpu_rd),
    .ppu_a10_i(a10), .ppu_a11_i(a11), .rom_addr_o(rom_addr),
    .rom_ce_o(rom_ce), .ciram_a10_o(ciram)
  );

  function automatic logic [5:0] mask_of(input logic [1:0] c);
    case (c)
      2'd0: return 6'h3f;
      2'd1: return 6'h1f;
      2'd2: return 6'h2f;
      default: return 6'h0f;
    endcase
  endfunction

  function automatic logic [19:0] exp_addr(input logic [15:0] a);
    logic [5:0] inn;
    logic [6:0] b;
    case (a[15:13])
      3'd3: inn = mb[3];
      3'd4: inn = mb[0];
      3'd5: inn = mb[1];
      3'd6: inn = mb[2];
      default: inn = 6'h3f;
    endcase
    b = {mo, 4'b0} | {1'b0, inn & mask_of(ms)};
    return {b, a[12:0]};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [15:0] a);
    cpu_addr = a; cpu_rd = 1'b1;
    #1;
    check(tag, 32'(rom_addr), 32'(exp_addr(a)));
  endtask

  task automatic all_windows(input string tag);
    rd_chk(tag, 16'h6123);
    rd_chk(tag, 16'h8456);
    rd_chk(tag, 16'ha789);
    rd_chk(tag, 16'hcabc);
    rd_chk(tag, 16'hfdef);
  endtask

  task automatic t_reset;
    for (int i = 0; i < 4; i++) mb[i] = '0;
    mo = '0; ms = '0;
    cpu_addr = 16'h8000; cpu_rd = 1'b1; #1;
    check("R1 addr at 8000", 32'(rom_addr), 32'h0);
    a10 = 1'b1; a11 = 1'b0; #1;
    check("R1 mirror vert a10=1", 32'(ciram), 32'h1);
    a10 = 1'b0; a11 = 1'b1; #1;
    check("R1 mirror vert a10=0", 32'(ciram), 32'h0);
    rd_chk("R4 reset fixed", 16'he000);
  endtask

  task automatic t_windows;
    wr(16'h8000, 8'h05); mb[0] = 6'h05;
    wr(16'h8001, 8'h0a); mb[1] = 6'h0a;
    wr(16'h8002, 8'h33); mb[2] = 6'h33;
    wr(16'h8003, 8'hec); mb[3] = 6'h2c;  // bits 7:6 dropped
    all_windows("R3 windows");
    rd_chk("R7 offset edge", 16'h7fff);
  endtask

  task automatic t_sizes;
    wr(16'h8000, 8'h3a); mb[0] = 6'h3a;
    for (int c = 0; c < 4; c++) begin
      wr(16'h9001, 8'(c) | 8'hfc); ms = 2'(c);
      rd_chk("R6 size inner", 16'h8000);
      rd_chk("R4 size fixed", 16'hffff);
    end
  endtask

  task automatic t_outer;
    wr(16'h9000, 8'he8); mo = 3'd5;
    rd_chk("R5 outer size3", 16'h8010);
    check("R5 outer bank value", 32'(rom_addr[19:13]), 32'h5a);
    wr(16'h9001, 8'h00); ms = 2'd0;
    rd_chk("R5 outer or-overlap", 16'h8010);
    check("R5 overlap value", 32'(rom_addr[19:13]), 32'h7a);
    all_windows("R5 outer windows");
  endtask

  task automatic t_alias;
    wr(16'h8ff6, 8'h11); mb[2] = 6'h11;
    wr(16'h9ff5, 8'h02); ms = 2'd2;
    all_windows("R2 alias");
  endtask

  task automatic t_ignored;
    wr(16'h9003, 8'hff);
    wr(16'ha000, 8'hff);
    wr(16'hb003, 8'hff);
    wr(16'hc001, 8'hff);
    wr(16'hf002, 8'hff);
    wr(16'h7003, 8'hff);
    wr(16'h8004 & 16'h7fff, 8'hff);
    all_windows("R10 ignored");
    a10 = 1'b1; a11 = 1'b0; #1;
    check("R10 mirror kept", 32'(ciram), 32'h1);
  endtask

  task automatic t_ce;
    cpu_rd = 1'b1; cpu_addr = 16'h5fff; #1;
    check("R8 ce below 6000", 32'(rom_ce), 32'h0);
    cpu_addr = 16'h6000; #1;
    check("R8 ce at 6000", 32'(rom_ce), 32'h1);
    cpu_addr = 16'hffff; #1;
    check("R8 ce at ffff", 32'(rom_ce), 32'h1);
    cpu_rd = 1'b0; cpu_addr = 16'h8000; #1;
    check("R8 ce no read", 32'(rom_ce), 32'h0);
  endtask

  task automatic t_mirror;
    logic [1:0] exp_v;
    for (int m = 0; m < 4; m++) begin
      wr(16'h9002, 8'(m));
      for (int p = 0; p < 2; p++) begin
        a10 = p[0]; a11 = ~p[0]; #1;
        case (m)
          0: exp_v = {1'b0, a10};
          1: exp_v = {1'b0, a11};
          2: exp_v = 2'd0;
          default: exp_v = 2'd1;
        endcase
        check("R9 mirror", 32'(ciram), 32'(exp_v));
      end
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_windows();
    t_sizes();
    t_outer();
    t_alias();
    t_ignored();
    t_ce();
    t_mirror();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule